// File: doc/BRIEF.md
# Capture-Compare General-Purpose Timer

This block is a programmable timer for software running on a host processor. It is built around one up-counter that advances by one on each clock while a run bit is set. The same counter serves four jobs. It can wrap to zero or reload from a preset value when it passes its maximum. It can signal when it equals a programmed match value. It can record its own value when an external event line changes.

Each of the three events (overflow, match and capture) sets its own sticky status bit. Software clears a status bit by writing a one to it. A separate enable register selects which status bits drive the single interrupt line.

Software reaches the block through a simple request/response register port with a 10-bit byte address and a 32-bit data path. Each request is answered exactly one clock later. The port accepts full-word and half-word accesses. It refuses byte accesses, misaligned accesses and unmapped addresses with an error response, and it leaves every register unchanged when it refuses.

Top module: `gp_timer`

## Requirements
- R1: After reset every register reads as zero, `irq` is low and `rsp_valid` is low.
- R2: While the run bit (CTRL bit 0) is 1, the count increases by exactly one per clock. While it is 0, the count holds its value.
- R3: When the count is 0xFFFFFFFF while running and autoreload (CTRL bit 1) is 0, the next count is 0 and ISTAT bit 0 (overflow) becomes 1.
- R4: With autoreload set, an overflow loads the count from the LOAD register instead of wrapping to zero.
- R5: With CTRL bit 2 set and the timer running, a count equal to MATCH sets ISTAT bit 1. With CTRL bit 2 clear, no match is flagged.
- R6: With CTRL bit 3 set, an edge on `evt_in` latches the count into CAPT and sets ISTAT bit 2. The input passes through two synchronizer flops and an edge-detect flop, so the capture lands three clocks after the input changes. CTRL bit 4 selects the edge: 0 means rising, 1 means falling. An edge of the other polarity has no effect.
- R7: ISTAT bits are sticky and are cleared by writing 1 to them. If an event and a clear of the same bit occur in the same clock, the event wins. `irq` is the OR of the ISTAT bits ANDed with the matching IEN bits.
- R8: The register map uses byte offsets: 0x00 CTRL, 0x04 COUNT, 0x08 LOAD, 0x0C MATCH, 0x10 CAPT, 0x14 ISTAT, 0x18 IEN. CAPT is read-only and a write to it is accepted but ignored. Every request gets `rsp_valid` one clock later, and read data arrives with it.
- R9: `req_size` encodes 0 as byte, 1 as half-word and 2 as word. A word access needs address bits [1:0] equal to 0. A half-word access needs address bit 0 equal to 0. Address bit 1 then selects `req_wdata[31:16]` (1) or `req_wdata[15:0]` (0), and the other half of the register is unchanged.
- R10: A byte access, a size of 3, a misaligned access or an unmapped offset returns `rsp_err` = 1 and read data 0, and changes no register.
- R11: A write to COUNT takes effect on the next clock. It overrides both the increment and the reload, including while the timer runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present this clock |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 10 | Byte address |
| req_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| req_wdata | input | 32 | Write data, half-words on their own lanes |
| evt_in | input | 1 | Asynchronous capture event line |
| rsp_valid | output | 1 | Response to the request of the previous clock |
| rsp_err | output | 1 | Request was refused |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are the counter boundary cases. Overflow, with or without reload, would take billions of clocks from reset. The stimulus therefore writes COUNT to a few counts below 0xFFFFFFFF while the timer is stopped, then sets the run bit, so the wrap happens within a handful of clocks. Capture-edge polarity is reached by switching the edge-select bit while the event line is held steady, then toggling the line in each direction. A reference model advanced on every clock compares the interrupt line and every response.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    // access size encoding on req_size
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // register word indices
    localparam int REG_CTRL  = 0;
    localparam int REG_COUNT = 1;
    localparam int REG_LOAD  = 2;
    localparam int REG_MATCH = 3;
    localparam int REG_CAPT  = 4;
    localparam int REG_ISTAT = 5;
    localparam int REG_IEN   = 6;
    localparam int NUM_REGS  = 7;

    // control bits
    localparam int CTRL_RUN    = 0;
    localparam int CTRL_RELOAD = 1;
    localparam int CTRL_CMP    = 2;
    localparam int CTRL_CAP    = 3;
    localparam int CTRL_FALL   = 4;
    localparam int CTRL_W      = 5;

    // interrupt causes
    localparam int IRQ_OVF  = 0;
    localparam int IRQ_HIT  = 1;
    localparam int IRQ_CAP  = 2;
    localparam int NUM_IRQ  = 3;

endpackage

// File: rtl/gpt_bus_decode.sv
module gpt_bus_decode
    import gpt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(DATA_W / 8),
    localparam int IDX_W = ADDR_W - OFF_W
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              acc_ok,
    output logic              rd_en,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic [DATA_W-1:0] wr_lanes
);
    localparam int HALVES = DATA_W / 16;

    logic [OFF_W-1:0] off;
    logic             in_map;
    logic             align_ok;

    always_comb begin
        reg_idx = req_addr[ADDR_W-1:OFF_W];
        off     = req_addr[OFF_W-1:0];
        in_map  = reg_idx < IDX_W'(NUM_REGS);
        case (req_size)
            SZ_WORD: align_ok = (off == '0);
            SZ_HALF: align_ok = (off[0] == 1'b0);
            default: align_ok = 1'b0;
        endcase
        acc_ok = req_valid && in_map && align_ok;
        rd_en  = acc_ok && !req_write;
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_lane
        assign wr_lanes[h*16 +: 16] =
            {16{(req_size == SZ_WORD) || (off[OFF_W-1:1] == (OFF_W-1)'(h))}};
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
        assign wr_sel[r] = acc_ok && req_write && (reg_idx == IDX_W'(r));
    end

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              autoreload,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] match_val,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_lanes,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt_q,
    output logic              ovf_pulse,
    output logic              hit_pulse
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        ovf_pulse = run && (st_q.cnt == '1);
        hit_pulse = run && cmp_en && (st_q.cnt == match_val);
        if (wr_en) begin
            st_d.cnt = (st_q.cnt & ~wr_lanes) | (wdata & wr_lanes);
        end else if (run) begin
            if (ovf_pulse) st_d.cnt = autoreload ? load_val : '0;
            else           st_d.cnt = st_q.cnt + DATA_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;

endmodule

// File: rtl/gpt_capture.sv
module gpt_capture #(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_in,
    input  logic              cap_en,
    input  logic              fall_sel,
    input  logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] capt_q,
    output logic              cap_pulse
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [DATA_W-1:0]      capt;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       synced;
    logic       edge_hit;

    always_comb begin
        st_d      = st_q;
        synced    = st_q.sync[SYNC_STAGES-1];
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], evt_in};
        st_d.prev = synced;
        edge_hit  = fall_sel ? (!synced && st_q.prev) : (synced && !st_q.prev);
        cap_pulse = cap_en && edge_hit;
        if (cap_pulse) st_d.capt = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign capt_q = st_q.capt;

endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gpt_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              evt_in,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq
);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int IDX_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic [CTRL_W-1:0]  ctrl;
        logic [DATA_W-1:0]  load;
        logic [DATA_W-1:0]  match;
        logic [NUM_IRQ-1:0] istat;
        logic [NUM_IRQ-1:0] ien;
        logic               rsp_valid;
        logic               rsp_err;
        logic [DATA_W-1:0]  rsp_rdata;
    } regs_t;

    regs_t q, d;

    logic                acc_ok;
    logic                rd_en;
    logic [IDX_W-1:0]    reg_idx;
    logic [NUM_REGS-1:0] wr_sel;
    logic [DATA_W-1:0]   wr_lanes;
    logic [DATA_W-1:0]   cnt_q;
    logic [DATA_W-1:0]   capt_q;
    logic                ovf_pulse;
    logic                hit_pulse;
    logic                cap_pulse;
    logic                ctrl_run;
    logic                ctrl_reload;
    logic                cnt_wr;
    logic                istat_wr;
    logic [DATA_W-1:0]   load_val;

    function automatic logic [DATA_W-1:0] merge_lanes(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [DATA_W-1:0] lanes
    );
        return (old_v & ~lanes) | (new_v & lanes);
    endfunction

    gpt_bus_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .acc_ok    (acc_ok),
        .rd_en     (rd_en),
        .reg_idx   (reg_idx),
        .wr_sel    (wr_sel),
        .wr_lanes  (wr_lanes)
    );

    assign ctrl_run    = q.ctrl[CTRL_RUN];
    assign ctrl_reload = q.ctrl[CTRL_RELOAD];
    assign cnt_wr      = wr_sel[REG_COUNT];
    assign istat_wr    = wr_sel[REG_ISTAT];
    assign load_val    = q.load;

    gpt_counter #(
        .DATA_W (DATA_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl_run),
        .autoreload (ctrl_reload),
        .cmp_en     (q.ctrl[CTRL_CMP]),
        .load_val   (q.load),
        .match_val  (q.match),
        .wr_en      (cnt_wr),
        .wr_lanes   (wr_lanes),
        .wdata      (req_wdata),
        .cnt_q      (cnt_q),
        .ovf_pulse  (ovf_pulse),
        .hit_pulse  (hit_pulse)
    );

    gpt_capture #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .cap_en    (q.ctrl[CTRL_CAP]),
        .fall_sel  (q.ctrl[CTRL_FALL]),
        .cnt       (cnt_q),
        .capt_q    (capt_q),
        .cap_pulse (cap_pulse)
    );

    logic [DATA_W-1:0]  rd_val;
    logic [DATA_W-1:0]  ctrl_new;
    logic [DATA_W-1:0]  ien_new;
    logic [DATA_W-1:0]  clr_word;
    logic [NUM_IRQ-1:0] clr_bits;
    logic [NUM_IRQ-1:0] set_bits;

    always_comb begin
        case (reg_idx)
            IDX_W'(REG_CTRL):  rd_val = DATA_W'(q.ctrl);
            IDX_W'(REG_COUNT): rd_val = cnt_q;
            IDX_W'(REG_LOAD):  rd_val = q.load;
            IDX_W'(REG_MATCH): rd_val = q.match;
            IDX_W'(REG_CAPT):  rd_val = capt_q;
            IDX_W'(REG_ISTAT): rd_val = DATA_W'(q.istat);
            IDX_W'(REG_IEN):   rd_val = DATA_W'(q.ien);
            default:           rd_val = '0;
        endcase

        d = q;

        d.rsp_valid = req_valid;
        d.rsp_err   = req_valid && !acc_ok;
        d.rsp_rdata = rd_en ? rd_val : '0;

        ctrl_new = merge_lanes(DATA_W'(q.ctrl), req_wdata, wr_lanes);
        ien_new  = merge_lanes(DATA_W'(q.ien), req_wdata, wr_lanes);
        if (wr_sel[REG_CTRL])  d.ctrl  = ctrl_new[CTRL_W-1:0];
        if (wr_sel[REG_LOAD])  d.load  = merge_lanes(q.load, req_wdata, wr_lanes);
        if (wr_sel[REG_MATCH]) d.match = merge_lanes(q.match, req_wdata, wr_lanes);
        if (wr_sel[REG_IEN])   d.ien   = ien_new[NUM_IRQ-1:0];

        clr_word = req_wdata & wr_lanes;
        clr_bits = istat_wr ? clr_word[NUM_IRQ-1:0] : '0;
        set_bits = '0;
        set_bits[IRQ_OVF] = ovf_pulse;
        set_bits[IRQ_HIT] = hit_pulse;
        set_bits[IRQ_CAP] = cap_pulse;
        d.istat = (q.istat & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid = q.rsp_valid;
    assign rsp_err   = q.rsp_err;
    assign rsp_rdata = q.rsp_rdata;
    assign irq       = |(q.istat & q.ien);

endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk #(
    parameter int DATA_W  = 32,
    parameter int NUM_IRQ = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_size,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] cnt_q,
    input logic [DATA_W-1:0] load_val,
    input logic [NUM_IRQ-1:0] istat_q,
    input logic              ctrl_run,
    input logic              ctrl_reload,
    input logic              cnt_wr,
    input logic              istat_wr
);
    // R2: one step per clock while running
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_run && !cnt_wr && (cnt_q != '1) |=> cnt_q == $past(cnt_q) + DATA_W'(1));

    // R2: frozen while stopped
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_run && !cnt_wr |=> $stable(cnt_q));

    // R3: wrap to zero and flag
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_run && !cnt_wr && (cnt_q == '1) && !ctrl_reload |=> (cnt_q == '0) && istat_q[0]);

    // R4: reload from preset
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_run && !cnt_wr && (cnt_q == '1) && ctrl_reload |=> cnt_q == $past(load_val));

    // R11: full-word count write lands next clock
    a_r11_cnt_write: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr && (req_size == 2'd2) |=> cnt_q == $past(req_wdata));

    // R8: one response per request, one clock later
    a_r8_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r8_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R10: byte access refused
    a_r10_byte_err: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_size == 2'd0) |=> rsp_err);

    // R7: overflow status is sticky until written
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        istat_q[0] && !istat_wr |=> istat_q[0]);

endmodule

bind gp_timer gp_timer_chk #(
    .DATA_W  (DATA_W),
    .NUM_IRQ (gpt_pkg::NUM_IRQ)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_size    (req_size),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .cnt_q       (cnt_q),
    .load_val    (load_val),
    .istat_q     (q.istat),
    .ctrl_run    (ctrl_run),
    .ctrl_reload (ctrl_reload),
    .cnt_wr      (cnt_wr),
    .istat_wr    (istat_wr)
);

// File: tb/gp_timer_test.sv
module gp_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic        evt_in = 1'b0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gp_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .evt_in    (evt_in),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .irq       (irq)
    );

    // ---------------- reference model ----------------
    logic [4:0]  m_ctrl;
    logic [31:0] m_cnt, m_load, m_match, m_capt;
    logic [2:0]  m_istat, m_ien;
    logic [1:0]  m_sync;
    logic        m_prev;
    logic        m_rsp_valid, m_rsp_err;
    logic [31:0] m_rsp_rdata;

    task automatic model_reset();
        m_ctrl = '0; m_cnt = '0; m_load = '0; m_match = '0; m_capt = '0;
        m_istat = '0; m_ien = '0; m_sync = '0; m_prev = 1'b0;
        m_rsp_valid = 1'b0; m_rsp_err = 1'b0; m_rsp_rdata = '0;
    endtask

    task automatic model_step();
        int idx;
        logic ok, wr, synced, ehit, cap, ovf, hit;
        logic [31:0] lanes, rv, t;
        logic [2:0] clr;
        idx = int'(req_addr[9:2]);
        ok = req_valid && (idx < 7) &&
             ((req_size == 2'd2 && req_addr[1:0] == 2'b00) ||
              (req_size == 2'd1 && req_addr[0] == 1'b0));
        wr = ok && req_write;
        lanes = (req_size == 2'd2) ? 32'hFFFF_FFFF :
                (req_addr[1] ? 32'hFFFF_0000 : 32'h0000_FFFF);
        case (idx)
            0: rv = {27'd0, m_ctrl};
            1: rv = m_cnt;
            2: rv = m_load;
            3: rv = m_match;
            4: rv = m_capt;
            5: rv = {29'd0, m_istat};
            6: rv = {29'd0, m_ien};
            default: rv = '0;
        endcase
        synced = m_sync[1];
        ehit = m_ctrl[4] ? (!synced && m_prev) : (synced && !m_prev);
        cap = m_ctrl[3] && ehit;
        ovf = m_ctrl[0] && (m_cnt == 32'hFFFF_FFFF);
        hit = m_ctrl[0] && m_ctrl[2] && (m_cnt == m_match);

        m_rsp_valid = req_valid;
        m_rsp_err   = req_valid && !ok;
        m_rsp_rdata = (ok && !req_write) ? rv : '0;

        if (cap) m_capt = m_cnt;
        m_prev = synced;
        m_sync = {m_sync[0], evt_in};

        if (wr && idx == 1)  m_cnt = (m_cnt & ~lanes) | (req_wdata & lanes);
        else if (m_ctrl[0])  m_cnt = ovf ? (m_ctrl[1] ? m_load : 32'd0) : m_cnt + 32'd1;

        t = req_wdata & lanes;
        clr = (wr && idx == 5) ? t[2:0] : 3'b000;
        m_istat = (m_istat & ~clr) | {cap, hit, ovf};

        if (wr && idx == 0) begin t = ({27'd0, m_ctrl} & ~lanes) | (req_wdata & lanes); m_ctrl = t[4:0]; end
        if (wr && idx == 2) m_load  = (m_load  & ~lanes) | (req_wdata & lanes);
        if (wr && idx == 3) m_match = (m_match & ~lanes) | (req_wdata & lanes);
        if (wr && idx == 6) begin t = ({29'd0, m_ien} & ~lanes) | (req_wdata & lanes); m_ien = t[2:0]; end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== |(m_istat & m_ien)) begin
                errors++;
                $display("FAIL R7 irq actual %0b expected %0b", irq, |(m_istat & m_ien));
            end
            checks++;
            if (rsp_valid !== m_rsp_valid || rsp_err !== m_rsp_err || rsp_rdata !== m_rsp_rdata) begin
                errors++;
                $display("FAIL R8 rsp actual v%0b e%0b %h expected v%0b e%0b %h",
                         rsp_valid, rsp_err, rsp_rdata, m_rsp_valid, m_rsp_err, m_rsp_rdata);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic acc(input logic w, input logic [9:0] a, input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_expect(input string tag, input logic [9:0] a, input logic [31:0] exp);
        acc(1'b0, a, 2'd2, 32'd0);
        expect32(tag, rsp_rdata, exp);
    endtask

    task automatic wr32(input logic [9:0] a, input logic [31:0] wd);
        acc(1'b1, a, 2'd2, wd);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        expect32("R1 irq", {31'd0, irq}, 32'd0);
        expect32("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        rd_expect("R1 ctrl", 10'h000, 32'd0);
        rd_expect("R1 count", 10'h004, 32'd0);
        rd_expect("R1 istat", 10'h014, 32'd0);

        // R2 stopped counter holds
        wr32(10'h004, 32'h1234_5678);
        idle(5);
        rd_expect("R2 frozen count", 10'h004, 32'h1234_5678);

        // R10 byte write refused, no change
        acc(1'b1, 10'h008, 2'd0, 32'hFFFF_FFFF);
        expect32("R10 byte err", {31'd0, rsp_err}, 32'd1);
        rd_expect("R10 load unchanged", 10'h008, 32'd0);
        acc(1'b1, 10'h009, 2'd2, 32'hFFFF_FFFF);
        expect32("R10 misaligned err", {31'd0, rsp_err}, 32'd1);
        acc(1'b1, 10'h009, 2'd1, 32'hFFFF_FFFF);
        expect32("R10 odd half err", {31'd0, rsp_err}, 32'd1);
        acc(1'b0, 10'h01C, 2'd2, 32'd0);
        expect32("R10 unmapped err", {31'd0, rsp_err}, 32'd1);
        expect32("R10 unmapped data", rsp_rdata, 32'd0);
        rd_expect("R10 load still zero", 10'h008, 32'd0);

        // R9 half-word lanes
        acc(1'b1, 10'h00A, 2'd1, 32'hABCD_0000);
        rd_expect("R9 upper half", 10'h008, 32'hABCD_0000);
        acc(1'b1, 10'h008, 2'd1, 32'h5555_1234);
        rd_expect("R9 lower half", 10'h008, 32'hABCD_1234);

        // R3 overflow wraps to zero
        wr32(10'h004, 32'hFFFF_FFFD);
        wr32(10'h018, 32'd1);
        wr32(10'h000, 32'd1);
        idle(10);
        wr32(10'h000, 32'd0);
        acc(1'b0, 10'h004, 2'd2, 32'd0);
        checks++;
        if (rsp_rdata >= 32'd16) begin
            errors++;
            $display("FAIL R3 wrapped count actual %h expected below 10", rsp_rdata);
        end
        rd_expect("R3 overflow flag", 10'h014, 32'd1);
        expect32("R7 irq enabled", {31'd0, irq}, 32'd1);
        wr32(10'h018, 32'd0);
        expect32("R7 irq masked", {31'd0, irq}, 32'd0);
        wr32(10'h014, 32'd1);
        rd_expect("R7 w1c cleared", 10'h014, 32'd0);

        // R4 autoreload
        wr32(10'h004, 32'hFFFF_FFFD);
        wr32(10'h000, 32'd3);
        idle(6);
        wr32(10'h000, 32'd0);
        acc(1'b0, 10'h004, 2'd2, 32'd0);
        checks++;
        if (rsp_rdata < 32'hABCD_1234 || rsp_rdata > 32'hABCD_1244) begin
            errors++;
            $display("FAIL R4 reload actual %h expected near abcd1234", rsp_rdata);
        end
        wr32(10'h014, 32'd7);

        // R5 compare enabled
        wr32(10'h00C, 32'h0000_0050);
        wr32(10'h004, 32'h0000_0040);
        wr32(10'h000, 32'd5);
        idle(40);
        wr32(10'h000, 32'd0);
        rd_expect("R5 match flag", 10'h014, 32'd2);
        wr32(10'h014, 32'd7);

        // R5 compare disabled
        wr32(10'h004, 32'h0000_0040);
        wr32(10'h000, 32'd1);
        idle(40);
        wr32(10'h000, 32'd0);
        rd_expect("R5 no match when disabled", 10'h014, 32'd0);

        // R11 count write while running
        wr32(10'h000, 32'd1);
        wr32(10'h004, 32'h0000_0500);
        rd_expect("R11 write next clock", 10'h004, 32'h0000_0501);

        // R6 rising-edge capture
        wr32(10'h000, 32'd9);
        wr32(10'h014, 32'd7);
        @(negedge clk); evt_in = 1'b1;
        idle(6);
        rd_expect("R6 rising capture flag", 10'h014, 32'd4);
        acc(1'b0, 10'h010, 2'd2, 32'd0);
        v = rsp_rdata;
        checks++;
        if (v < 32'h0000_0500) begin
            errors++;
            $display("FAIL R6 capt actual %h expected at least 500", v);
        end

        // R8 capture register is read-only
        wr32(10'h010, 32'hDEAD_BEEF);
        expect32("R8 capt write accepted", {31'd0, rsp_err}, 32'd0);
        rd_expect("R8 capt unchanged", 10'h010, v);

        // R6 falling-edge select
        wr32(10'h000, 32'h19);
        wr32(10'h014, 32'd7);
        @(negedge clk); evt_in = 1'b0;
        idle(6);
        rd_expect("R6 falling capture flag", 10'h014, 32'd4);
        wr32(10'h014, 32'd7);
        @(negedge clk); evt_in = 1'b1;
        idle(6);
        rd_expect("R6 rising ignored in falling mode", 10'h014, 32'd0);
        wr32(10'h000, 32'd0);

        idle(4);
        finish_run();
    end

endmodule